// File: doc/BRIEF.md
# Loop Buffer Wavelength Slot Allocator

This block keeps the occupancy map of a bank of recirculating optical loop buffer modules that sit behind the upper half of a core space switch. Each module stores packets on a set of storage wavelength channels. It owns a fixed group of core-switch ports, and it has a limited number of write converters and read filters. The block is purely a bookkeeper. In every slot, one clock cycle, it takes a set of write requests (packets that lost output contention and must be stored) and a set of read requests (stored packets that the scheduler has chosen to release). In the same cycle it returns the place where each packet goes.

For a write, the block returns the module, the storage channel and the core-switch port to use. If no module can take the packet, it raises a reject flag so that the scheduler drops it. For a read, it returns the read-out channel, the matching wavelength code and the core-switch port, together with the output tag recorded when the packet was stored. It also frees the storage channel. Reads are settled before writes, so a channel released in a slot can be refilled in that same slot. Requests inside each group are served in lane order, lane 0 first.

Top module: `wsa_top`

## Requirements
- R1: While reset is held, and after it is released, every storage channel is free. No read request is granted until a channel has been written.
- R2: A granted write goes to the lowest-numbered module that still has a free write port and a free storage channel in this slot. Inside that module it takes the lowest-indexed free channel.
- R3: A module grants at most D writes in one slot. Later write lanes move on to the next module.
- R4: The write port of a grant is the module's D-th-in-order converter: the first grant to a module in a slot uses port 0, the next port 1, and so on. The reported core-switch port is N + module·D + write port.
- R5: A write that no module can accept gets wr_rej=1 and wr_ok=0, and it leaves every stored channel and tag unchanged.
- R6: A read of an occupied channel is granted. It returns the stored output tag and a read-out port numbered from 0 upward in lane order per module. It also returns the wavelength code B + read-out port and the core-switch port N + module·D + read-out port.
- R7: A read of an unoccupied channel, of a channel index of B or more, or of a channel already read by an earlier lane in the same slot is refused (rd_ok=0) and changes nothing.
- R8: A module grants at most D reads in one slot. A refused excess read leaves its channel occupied for a later slot.
- R9: A granted read frees its channel at the end of the slot. A write in the same slot may be given that channel.
- R10: An occupied channel keeps its tag and is never handed to a write until it has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | WRL | Write request per lane |
| wr_tag | input | WRL×TAGW | Destination output tag per write lane |
| wr_ok | output | WRL | Write granted |
| wr_rej | output | WRL | Write requested but refused |
| wr_mod | output | WRL×MW | Module chosen for the write |
| wr_ch | output | WRL×BW | Storage channel chosen |
| wr_port | output | WRL×PW | Core-switch port for the write |
| rd_req | input | RDL | Read request per lane |
| rd_mod | input | RDL×MW | Module holding the packet |
| rd_ch | input | RDL×BW | Storage channel holding the packet |
| rd_ok | output | RDL | Read granted |
| rd_port | output | RDL×DW | Read-out port inside the module |
| rd_code | output | RDL×CODEW | Read-out wavelength code (B + port) |
| rd_core | output | RDL×PW | Core-switch port the packet leaves on |
| rd_tag | output | RDL×TAGW | Output tag stored with the packet |

## Verification
Every grant, channel, port, code and tag is a combinational answer to the requests of the current slot. The bench drives requests just after a falling edge and compares these outputs a quarter period later, before the next rising edge. The occupancy change caused by a slot becomes visible only in the answers of the following slot, after one register stage. The reference model therefore commits its own channel map at the rising edge and uses the new map from the next slot on. Refusals (R5, R7, R8) are confirmed by reading the affected channels in later slots and seeing them granted with their old tags.

// File: rtl/wsa_pkg.sv
// Shared helpers for the wavelength slot allocator.
// Assumes nothing beyond elaboration-time integer arithmetic.
package wsa_pkg;

    // Bits needed to index n items (at least one bit)
    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wsa_chan_store.sv
// Channel state store: one valid bit and one output tag per storage
// channel of every module.
// Assumes next occupancy is fully computed by the caller; tag writes only
// touch channels flagged in tag_we.
module wsa_chan_store #(
    parameter int M    = 4,
    parameter int B    = 6,
    parameter int TAGW = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [M-1:0][B-1:0]              valid_d,
    input  logic [M-1:0][B-1:0]              tag_we,
    input  logic [M-1:0][B-1:0][TAGW-1:0]    tag_wd,
    output logic [M-1:0][B-1:0]              valid_q,
    output logic [M-1:0][B-1:0][TAGW-1:0]    tag_q
);

    // Occupancy register; reset frees every channel
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // Tag register; loaded per channel on a granted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            for (int k = 0; k < M; k++) begin
                for (int c = 0; c < B; c++) begin
                    if (tag_we[k][c]) tag_q[k][c] <= tag_wd[k][c];
                end
            end
        end
    end

endmodule

// File: rtl/wsa_read_arb.sv
// Read arbiter: grants read lanes in lane order, hands out read-out ports
// per module in ascending order and marks the channels to be freed.
// Assumes the caller supplies the registered occupancy and tags.
module wsa_read_arb #(
    parameter int M    = 4,
    parameter int B    = 6,
    parameter int D    = 2,
    parameter int RDL  = 4,
    parameter int TAGW = 4,
    parameter int MW   = 2,
    parameter int BW   = 3,
    parameter int DW   = 1
) (
    input  logic [RDL-1:0]                 rd_req,
    input  logic [RDL-1:0][MW-1:0]         rd_mod,
    input  logic [RDL-1:0][BW-1:0]         rd_ch,
    input  logic [M-1:0][B-1:0]            valid_q,
    input  logic [M-1:0][B-1:0][TAGW-1:0]  tag_q,
    output logic [RDL-1:0]                 rd_ok,
    output logic [RDL-1:0][DW-1:0]         rd_port,
    output logic [RDL-1:0][TAGW-1:0]       rd_tag,
    output logic [M-1:0][B-1:0]            clr
);

    int cnt [M];

    // Walk lanes in order, granting occupied channels while read ports last
    always_comb begin
        clr     = '0;
        rd_ok   = '0;
        rd_port = '0;
        rd_tag  = '0;
        for (int k = 0; k < M; k++) cnt[k] = 0;
        for (int i = 0; i < RDL; i++) begin
            if (rd_req[i] && int'(rd_mod[i]) < M && int'(rd_ch[i]) < B) begin
                if (valid_q[rd_mod[i]][rd_ch[i]] && !clr[rd_mod[i]][rd_ch[i]]
                    && cnt[rd_mod[i]] < D) begin
                    rd_ok[i]                  = 1'b1;
                    rd_port[i]                = DW'(cnt[rd_mod[i]]);
                    rd_tag[i]                 = tag_q[rd_mod[i]][rd_ch[i]];
                    clr[rd_mod[i]][rd_ch[i]]  = 1'b1;
                    cnt[rd_mod[i]]            = cnt[rd_mod[i]] + 1;
                end
            end
        end
    end

endmodule

// File: rtl/wsa_write_lane.sv
// One write lane of the allocation chain: finds the lowest module with a
// free converter and a free channel, then the lowest free channel in it.
// Assumes occ_in already holds reads freed and earlier lanes' claims.
module wsa_write_lane #(
    parameter int N  = 16,
    parameter int M  = 4,
    parameter int B  = 6,
    parameter int D  = 2,
    parameter int MW = 2,
    parameter int BW = 3,
    parameter int CW = 2,
    parameter int PW = 5
) (
    input  logic                  req,
    input  logic [M-1:0][B-1:0]   occ_in,
    input  logic [M-1:0][CW-1:0]  wcnt_in,
    output logic                  ok,
    output logic [MW-1:0]         mod,
    output logic [BW-1:0]         ch,
    output logic [PW-1:0]         port,
    output logic [M-1:0][B-1:0]   occ_out,
    output logic [M-1:0][CW-1:0]  wcnt_out
);

    // Priority search, downward loops so the lowest index is kept last
    always_comb begin
        ok       = 1'b0;
        mod      = '0;
        ch       = '0;
        port     = '0;
        occ_out  = occ_in;
        wcnt_out = wcnt_in;
        if (req) begin
            for (int k = M - 1; k >= 0; k--) begin
                if (int'(wcnt_in[k]) < D && !(&occ_in[k])) begin
                    ok  = 1'b1;
                    mod = MW'(k);
                end
            end
            if (ok) begin
                for (int c = B - 1; c >= 0; c--) begin
                    if (!occ_in[mod][c]) ch = BW'(c);
                end
                port          = PW'(N + int'(mod) * D + int'(wcnt_in[mod]));
                occ_out[mod][ch] = 1'b1;
                wcnt_out[mod] = wcnt_in[mod] + CW'(1);
            end
        end
    end

endmodule

// File: rtl/wsa_top.sv
// Wavelength slot allocator top: one slot per clock. Reads are settled
// first, then write lanes claim channels through a chain of lane stages.
// Assumes M*D <= N so every module port lies inside the core switch.
module wsa_top
    import wsa_pkg::*;
#(
    parameter int N     = 16,
    parameter int M     = 4,
    parameter int B     = 6,
    parameter int D     = 2,
    parameter int WRL   = 4,
    parameter int RDL   = 4,
    parameter int TAGW  = 4,
    localparam int MW    = bits_for(M),
    localparam int BW    = bits_for(B),
    localparam int DW    = bits_for(D),
    localparam int CW    = bits_for(D + 1),
    localparam int CODEW = bits_for(B + D),
    localparam int PW    = bits_for(N + M * D)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WRL-1:0]             wr_req,
    input  logic [WRL-1:0][TAGW-1:0]   wr_tag,
    output logic [WRL-1:0]             wr_ok,
    output logic [WRL-1:0]             wr_rej,
    output logic [WRL-1:0][MW-1:0]     wr_mod,
    output logic [WRL-1:0][BW-1:0]     wr_ch,
    output logic [WRL-1:0][PW-1:0]     wr_port,
    input  logic [RDL-1:0]             rd_req,
    input  logic [RDL-1:0][MW-1:0]     rd_mod,
    input  logic [RDL-1:0][BW-1:0]     rd_ch,
    output logic [RDL-1:0]             rd_ok,
    output logic [RDL-1:0][DW-1:0]     rd_port,
    output logic [RDL-1:0][CODEW-1:0]  rd_code,
    output logic [RDL-1:0][PW-1:0]     rd_core,
    output logic [RDL-1:0][TAGW-1:0]   rd_tag
);

    logic [M-1:0][B-1:0]            valid_q;
    logic [M-1:0][B-1:0][TAGW-1:0]  tag_q;
    logic [M-1:0][B-1:0]            rd_clr;
    logic [M-1:0][B-1:0]            valid_d;
    logic [M-1:0][B-1:0]            tag_we;
    logic [M-1:0][B-1:0][TAGW-1:0]  tag_wd;
    logic [M-1:0][B-1:0]            occ_chain  [WRL+1];
    logic [M-1:0][CW-1:0]           wcnt_chain [WRL+1];

    wsa_chan_store #(.M(M), .B(B), .TAGW(TAGW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_d (valid_d),
        .tag_we  (tag_we),
        .tag_wd  (tag_wd),
        .valid_q (valid_q),
        .tag_q   (tag_q)
    );

    wsa_read_arb #(
        .M(M), .B(B), .D(D), .RDL(RDL), .TAGW(TAGW),
        .MW(MW), .BW(BW), .DW(DW)
    ) u_rd (
        .rd_req  (rd_req),
        .rd_mod  (rd_mod),
        .rd_ch   (rd_ch),
        .valid_q (valid_q),
        .tag_q   (tag_q),
        .rd_ok   (rd_ok),
        .rd_port (rd_port),
        .rd_tag  (rd_tag),
        .clr     (rd_clr)
    );

    // Chain head: occupancy after this slot's reads, no ports used yet
    assign occ_chain[0]  = valid_q & ~rd_clr;
    assign wcnt_chain[0] = '0;

    for (genvar i = 0; i < WRL; i++) begin : g_wlane
        wsa_write_lane #(
            .N(N), .M(M), .B(B), .D(D),
            .MW(MW), .BW(BW), .CW(CW), .PW(PW)
        ) u_lane (
            .req      (wr_req[i]),
            .occ_in   (occ_chain[i]),
            .wcnt_in  (wcnt_chain[i]),
            .ok       (wr_ok[i]),
            .mod      (wr_mod[i]),
            .ch       (wr_ch[i]),
            .port     (wr_port[i]),
            .occ_out  (occ_chain[i+1]),
            .wcnt_out (wcnt_chain[i+1])
        );
    end

    assign valid_d = occ_chain[WRL];
    assign wr_rej  = wr_req & ~wr_ok;

    // Route each granted write lane's tag to its claimed channel
    always_comb begin
        tag_we = '0;
        tag_wd = '0;
        for (int i = 0; i < WRL; i++) begin
            if (wr_ok[i]) begin
                tag_we[wr_mod[i]][wr_ch[i]] = 1'b1;
                tag_wd[wr_mod[i]][wr_ch[i]] = wr_tag[i];
            end
        end
    end

    // Derive the read-out wavelength code and core-switch exit port
    always_comb begin
        for (int i = 0; i < RDL; i++) begin
            rd_code[i] = '0;
            rd_core[i] = '0;
            if (rd_ok[i]) begin
                rd_code[i] = CODEW'(B + int'(rd_port[i]));
                rd_core[i] = PW'(N + int'(rd_mod[i]) * D + int'(rd_port[i]));
            end
        end
    end

endmodule

// File: rtl/wsa_checker.sv
// Property checker for the slot allocator, bound into wsa_top.
// Assumes it sees the registered occupancy and this slot's read clears.
module wsa_checker
    import wsa_pkg::*;
#(
    parameter int N    = 16,
    parameter int M    = 4,
    parameter int B    = 6,
    parameter int D    = 2,
    parameter int WRL  = 4,
    parameter int RDL  = 4,
    localparam int MW  = bits_for(M),
    localparam int BW  = bits_for(B),
    localparam int DW  = bits_for(D),
    localparam int PW  = bits_for(N + M * D)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [WRL-1:0]          wr_ok,
    input logic [WRL-1:0][MW-1:0]  wr_mod,
    input logic [WRL-1:0][BW-1:0]  wr_ch,
    input logic [WRL-1:0][PW-1:0]  wr_port,
    input logic [RDL-1:0]          rd_ok,
    input logic [RDL-1:0][MW-1:0]  rd_mod,
    input logic [RDL-1:0][BW-1:0]  rd_ch,
    input logic [RDL-1:0][DW-1:0]  rd_port,
    input logic [M-1:0][B-1:0]     valid_q,
    input logic [M-1:0][B-1:0]     clr
);

    // R1: the first slot after reset sees an empty store
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0));

    for (genvar i = 0; i < WRL; i++) begin : g_wr
        // R10 / R9: a write only lands on a free or just-freed channel
        assert_write_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_ok[i] |-> (!valid_q[wr_mod[i]][wr_ch[i]] || clr[wr_mod[i]][wr_ch[i]]));
        // R4: the core port lies in the chosen module's window
        assert_port_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_ok[i] |-> ((int'(wr_port[i]) >= N + int'(wr_mod[i]) * D)
                       && (int'(wr_port[i]) <  N + (int'(wr_mod[i]) + 1) * D)));
    end

    for (genvar i = 0; i < RDL; i++) begin : g_rd
        // R7: only occupied channels are granted for read
        assert_read_occupied_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ok[i] |-> valid_q[rd_mod[i]][rd_ch[i]]);
        // R6: read-out port index stays below D
        assert_read_port_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ok[i] |-> (int'(rd_port[i]) < D));
    end

    for (genvar k = 0; k < M; k++) begin : g_mod
        int wn;
        int rn;
        // Count grants landing on module k in this slot
        always_comb begin
            wn = 0;
            rn = 0;
            for (int i = 0; i < WRL; i++) if (wr_ok[i] && int'(wr_mod[i]) == k) wn++;
            for (int i = 0; i < RDL; i++) if (rd_ok[i] && int'(rd_mod[i]) == k) rn++;
        end
        assert_write_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            wn <= D);
        assert_read_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rn <= D);
    end

endmodule

bind wsa_top wsa_checker #(
    .N(N), .M(M), .B(B), .D(D), .WRL(WRL), .RDL(RDL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (wr_ok),
    .wr_mod  (wr_mod),
    .wr_ch   (wr_ch),
    .wr_port (wr_port),
    .rd_ok   (rd_ok),
    .rd_mod  (rd_mod),
    .rd_ch   (rd_ch),
    .rd_port (rd_port),
    .valid_q (valid_q),
    .clr     (rd_clr)
);

// File: tb/wsa_top_tb.sv
// Self-checking bench: behavioural slot model compared every slot.
module wsa_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16, M = 4, B = 6, D = 2, WRL = 4, RDL = 4, TAGW = 4;
    localparam int MW = 2, BW = 3, DW = 1, CODEW = 3, PW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WRL-1:0]            wr_req;
    logic [WRL-1:0][TAGW-1:0]  wr_tag;
    logic [WRL-1:0]            wr_ok, wr_rej;
    logic [WRL-1:0][MW-1:0]    wr_mod;
    logic [WRL-1:0][BW-1:0]    wr_ch;
    logic [WRL-1:0][PW-1:0]    wr_port;
    logic [RDL-1:0]            rd_req;
    logic [RDL-1:0][MW-1:0]    rd_mod;
    logic [RDL-1:0][BW-1:0]    rd_ch;
    logic [RDL-1:0]            rd_ok;
    logic [RDL-1:0][DW-1:0]    rd_port;
    logic [RDL-1:0][CODEW-1:0] rd_code;
    logic [RDL-1:0][PW-1:0]    rd_core;
    logic [RDL-1:0][TAGW-1:0]  rd_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsa_top #(.N(N), .M(M), .B(B), .D(D), .WRL(WRL), .RDL(RDL), .TAGW(TAGW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_tag(wr_tag), .wr_ok(wr_ok), .wr_rej(wr_rej),
        .wr_mod(wr_mod), .wr_ch(wr_ch), .wr_port(wr_port),
        .rd_req(rd_req), .rd_mod(rd_mod), .rd_ch(rd_ch), .rd_ok(rd_ok),
        .rd_port(rd_port), .rd_code(rd_code), .rd_core(rd_core), .rd_tag(rd_tag)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int mv [M][B];
    int mt [M][B];

    task automatic chk(string ctx, string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL [%s] %s %s: actual=%0d expected=%0d", ctx, req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < M; k++)
            for (int c = 0; c < B; c++) begin mv[k][c] = 0; mt[k][c] = 0; end
    endtask

    task automatic idle();
        wr_req = '0; wr_tag = '0; rd_req = '0; rd_mod = '0; rd_ch = '0;
    endtask

    task automatic add_wr(int lane, int tag);
        wr_req[lane] = 1'b1; wr_tag[lane] = TAGW'(tag);
    endtask

    task automatic add_rd(int lane, int m, int c);
        rd_req[lane] = 1'b1; rd_mod[lane] = MW'(m); rd_ch[lane] = BW'(c);
    endtask

    // Caller drives inputs after a falling edge, then calls this
    task automatic run_slot(string ctx);
        int rc [M]; int wc [M]; int fr [M][B]; int oc [M][B]; int nt [M][B];
        int m, c, eo, ep, fk, fc;
        #(CLK_PERIOD/4);
        for (int k = 0; k < M; k++) begin
            rc[k] = 0; wc[k] = 0;
            for (int j = 0; j < B; j++) begin fr[k][j] = 0; nt[k][j] = mt[k][j]; end
        end
        for (int i = 0; i < RDL; i++) begin
            eo = 0; ep = 0; m = int'(rd_mod[i]); c = int'(rd_ch[i]);
            if (rd_req[i] && c < B) begin
                if (mv[m][c] != 0 && fr[m][c] == 0 && rc[m] < D) begin
                    eo = 1; ep = rc[m]; rc[m]++; fr[m][c] = 1;
                end
            end
            chk(ctx, "R7", "rd_ok", int'(rd_ok[i]), eo);
            if (eo != 0) begin
                chk(ctx, "R6", "rd_port", int'(rd_port[i]), ep);
                chk(ctx, "R6", "rd_code", int'(rd_code[i]), B + ep);
                chk(ctx, "R6", "rd_core", int'(rd_core[i]), N + m * D + ep);
                chk(ctx, "R10", "rd_tag", int'(rd_tag[i]), mt[m][c]);
            end
        end
        for (int k = 0; k < M; k++)
            for (int j = 0; j < B; j++) oc[k][j] = (mv[k][j] != 0 && fr[k][j] == 0) ? 1 : 0;
        for (int i = 0; i < WRL; i++) begin
            fk = -1; fc = -1;
            if (wr_req[i]) begin
                for (int k = 0; k < M && fk < 0; k++) begin
                    if (wc[k] < D)
                        for (int j = 0; j < B && fc < 0; j++)
                            if (oc[k][j] == 0) begin fk = k; fc = j; end
                end
            end
            chk(ctx, "R2", "wr_ok", int'(wr_ok[i]), (fk >= 0) ? 1 : 0);
            chk(ctx, "R5", "wr_rej", int'(wr_rej[i]), (wr_req[i] && fk < 0) ? 1 : 0);
            if (fk >= 0) begin
                chk(ctx, "R2", "wr_mod", int'(wr_mod[i]), fk);
                chk(ctx, "R2", "wr_ch", int'(wr_ch[i]), fc);
                chk(ctx, "R4", "wr_port", int'(wr_port[i]), N + fk * D + wc[fk]);
                wc[fk]++; oc[fk][fc] = 1; nt[fk][fc] = int'(wr_tag[i]);
            end
        end
        @(posedge clk);
        for (int k = 0; k < M; k++)
            for (int j = 0; j < B; j++) begin mv[k][j] = oc[k][j]; mt[k][j] = nt[k][j]; end
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        clear_model();
        @(negedge clk); rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL [WDOG] timeout: actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        clear_model();
        do_reset();

        // R1: every channel refuses a read right after reset
        for (int k = 0; k < M; k++) begin
            @(negedge clk); idle();
            for (int j = 0; j < B && j < RDL; j++) add_rd(j, k, j);
            run_slot("R1");
            @(negedge clk); idle();
            for (int j = RDL; j < B; j++) add_rd(j - RDL, k, j);
            run_slot("R1");
        end

        // R2 R3 R4: four writes; two per module, ports ascending
        @(negedge clk); idle();
        for (int i = 0; i < WRL; i++) add_wr(i, i + 1);
        run_slot("R3");
        @(negedge clk); idle(); add_wr(2, 9);
        run_slot("R2");

        // R8: three reads on module 0, the third is refused
        @(negedge clk); idle();
        add_rd(0, 0, 0); add_rd(1, 0, 1); add_rd(2, 0, 2);
        run_slot("R8");
        @(negedge clk); idle(); add_rd(0, 0, 2);
        run_slot("R8");

        // R7: duplicate, empty and out-of-range channel reads
        @(negedge clk); idle();
        add_rd(0, 1, 0); add_rd(1, 1, 0); add_rd(2, 3, 5); add_rd(3, 1, 7);
        run_slot("R7");

        // R9: read frees module 0 channel 0 while a write reuses it
        @(negedge clk); idle(); add_wr(0, 5);
        run_slot("R9");
        @(negedge clk); idle(); add_rd(0, 0, 0); add_wr(0, 12);
        run_slot("R9");

        // R5 R10: fill the store, then overflow
        for (int s = 0; s < 8; s++) begin
            @(negedge clk); idle();
            for (int i = 0; i < WRL; i++) add_wr(i, (s * 3 + i) % 16);
            run_slot("R5");
        end
        @(negedge clk); idle(); add_wr(0, 15); add_wr(3, 14);
        run_slot("R5");
        for (int k = 0; k < M; k++)
            for (int j = 0; j < B; j += 2) begin
                @(negedge clk); idle(); add_rd(0, k, j); add_rd(1, k, j + 1);
                run_slot("R10");
            end

        // R1: reset with a partly filled store drops everything
        @(negedge clk); idle();
        for (int i = 0; i < WRL; i++) add_wr(i, 7);
        run_slot("R1");
        do_reset();
        @(negedge clk); idle();
        add_rd(0, 0, 0); add_rd(1, 0, 1); add_rd(2, 1, 0); add_wr(0, 3);
        run_slot("R1");

        // Mixed traffic
        for (int s = 0; s < 400; s++) begin
            @(negedge clk); idle();
            for (int i = 0; i < WRL; i++)
                if ($urandom_range(0, 99) < 45) add_wr(i, $urandom_range(0, 15));
            for (int i = 0; i < RDL; i++)
                if ($urandom_range(0, 99) < 50)
                    add_rd(i, $urandom_range(0, M - 1), $urandom_range(0, 7));
            run_slot("MIX");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule